// File: doc/BRIEF.md
# Twisted-Ring Counter with Two-Bit State Decode

This block is a synchronous twisted-ring (Johnson) counter. A chain of `STAGES` flip-flops shifts by one place on every enabled clock. The inverted output of the last stage is fed back into the first stage, so the chain walks through `2*STAGES` distinct patterns before it repeats. With the default of four stages the counter is modulus 8.

Beside the raw stage bits, the block provides a one-hot vector with one line per state. Each decode line is a two-input AND of a pair of stage bits, taken either from neighbouring stages or from the two ends of the chain. The decode is computed from the next-state value and registered together with the stages, so the outputs change on the same edge and have no glitches. A synchronous clear returns the chain to the all-zero state. A parallel load can place any pattern in the chain, which serves for seeding and for test. If the chain ever holds a pattern outside the legal sequence, it is steered back into that sequence within a bounded number of clocks.

Top module: `johnson_ring_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next value of `stages` is all zero and `state_hot` has only bit 0 set, whatever `clr`, `load_en` and `en` hold.
- R2: With `en` high and no clear or load, a legal chain advances one state per clock. `stages[0]` is the first stage, it receives the inverted `stages[STAGES-1]`, and every other stage receives its lower neighbour. For four stages the values of `stages` run 0x0, 0x1, 0x3, 0x7, 0xF, 0xE, 0xC, 0x8 as states 0 to 7, and the sequence then wraps back to 0x0.
- R3: With `en` low and no clear or load, a legal state holds: `stages` and `state_hot` do not change.
- R4: When `clr` is high, the chain is all zero after the next edge, and `state_hot` shows only bit 0. This takes priority over `load_en` and `en`.
- R5: When `load_en` is high and `clr` is low, `stages` takes `load_val` at the next edge, whether `en` is high or low. Illegal patterns are loaded as well.
- R6: In a legal state k, exactly bit k of `state_hot` is high. The decodes are as follows. State 0 is ~first & ~last. State s for 1..STAGES-1 is stages[s-1] & ~stages[s]. State STAGES is first & last. State STAGES+j for 1..STAGES-1 is ~stages[j-1] & stages[j].
- R7: A pattern outside the legal sequence is corrected without any clear or load, whatever `en` holds. In the default mode (`RECOVER_CLEAR`) the chain reaches all zero at the next edge. In the drain mode, zeros are shifted in until the pattern is legal, which takes fewer than `STAGES` clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear to state 0 |
| en | input | 1 | Step enable |
| load_en | input | 1 | Parallel load strobe |
| load_val | input | STAGES | Pattern to load, bit 0 is the first stage |
| stages | output | STAGES | Registered stage bits |
| state_hot | output | 2*STAGES | Registered one-hot state decode |

## Verification
Two functions can act in the same cycle. The first pair is clear together with load and step. The second pair is illegal-pattern recovery together with a held enable. Clear is driven in the same cycle as a load of a different legal value and with `en` high. The only accepted result is state 0, which shows that clear takes priority. Every one of the eight illegal four-bit patterns is loaded and then left with `en` low. The chain must show the loaded pattern for one cycle, then state 0 with bit 0 decoded, which shows that recovery ignores the hold.

// File: rtl/jc_pkg.sv
`timescale 1ns/1ps
package jc_pkg;
  // How an out-of-sequence pattern is brought back into the ring.
  typedef enum logic {
    RECOVER_CLEAR = 1'b0,  // jump to the all-zero state in one clock
    RECOVER_DRAIN = 1'b1   // shift zeros in until the pattern is legal
  } jc_recover_e;
endpackage

// File: rtl/jc_legal_detect.sv
`timescale 1ns/1ps
// A legal twisted-ring pattern has at most one edge between adjacent stages
// along the open chain (a run of ones against a run of zeros).
module jc_legal_detect #(
  parameter int STAGES = 4
) (
  input  logic [STAGES-1:0] chain,
  output logic              legal
);
  localparam int CW = $clog2(STAGES) + 1;

  logic [STAGES-2:0] edge_v;
  logic [CW-1:0]     edge_cnt;

  genvar g;
  generate
    for (g = 0; g < STAGES - 1; g++) begin : g_edge
      assign edge_v[g] = chain[g] ^ chain[g+1];
    end
  endgenerate

  always_comb begin
    edge_cnt = '0;
    for (int i = 0; i < STAGES - 1; i++) begin
      edge_cnt = edge_cnt + CW'(edge_v[i]);
    end
    legal = (edge_cnt <= CW'(1));
  end
endmodule

// File: rtl/jc_next_state.sv
`timescale 1ns/1ps
module jc_next_state #(
  parameter int                  STAGES = 4,
  parameter jc_pkg::jc_recover_e MODE   = jc_pkg::RECOVER_CLEAR
) (
  input  logic [STAGES-1:0] cur,
  input  logic              legal,
  input  logic              clr,
  input  logic              load_en,
  input  logic [STAGES-1:0] load_val,
  input  logic              en,
  output logic [STAGES-1:0] nxt
);
  logic [STAGES-1:0] stepped;
  logic [STAGES-1:0] repaired;

  // Twisted feedback: the inverted last stage enters the first stage.
  assign stepped = {cur[STAGES-2:0], ~cur[STAGES-1]};

  generate
    if (MODE == jc_pkg::RECOVER_CLEAR) begin : g_rec_clear
      assign repaired = '0;
    end else begin : g_rec_drain
      assign repaired = {cur[STAGES-2:0], 1'b0};
    end
  endgenerate

  always_comb begin
    if (clr)          nxt = '0;
    else if (load_en) nxt = load_val;
    else if (!legal)  nxt = repaired;
    else if (en)      nxt = stepped;
    else              nxt = cur;
  end
endmodule

// File: rtl/jc_decode.sv
`timescale 1ns/1ps
// Two-input decode of every ring state.
module jc_decode #(
  parameter int STAGES = 4
) (
  input  logic [STAGES-1:0]   chain,
  output logic [2*STAGES-1:0] hot
);
  assign hot[0]      = ~chain[0] & ~chain[STAGES-1];
  assign hot[STAGES] =  chain[0] &  chain[STAGES-1];

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_pair
      assign hot[s]        =  chain[s-1] & ~chain[s];
      assign hot[STAGES+s] = ~chain[s-1] &  chain[s];
    end
  endgenerate
endmodule

// File: rtl/johnson_ring_decoder.sv
`timescale 1ns/1ps
module johnson_ring_decoder #(
  parameter int                  STAGES = 4,
  parameter jc_pkg::jc_recover_e MODE   = jc_pkg::RECOVER_CLEAR
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  en,
  input  logic                  load_en,
  input  logic [STAGES-1:0]     load_val,
  output logic [STAGES-1:0]     stages,
  output logic [2*STAGES-1:0]   state_hot
);
  localparam int NSTATE = 2 * STAGES;
  localparam logic [NSTATE-1:0] HOT_ZERO = {{(NSTATE-1){1'b0}}, 1'b1};

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic [NSTATE-1:0] hot_q;
  logic [NSTATE-1:0] hot_d;
  logic              cur_legal;

  jc_legal_detect #(.STAGES(STAGES)) legal_i (
    .chain (chain_q),
    .legal (cur_legal)
  );

  jc_next_state #(.STAGES(STAGES), .MODE(MODE)) next_i (
    .cur      (chain_q),
    .legal    (cur_legal),
    .clr      (clr),
    .load_en  (load_en),
    .load_val (load_val),
    .en       (en),
    .nxt      (chain_d)
  );

  // Decode the next value so the registered decode lines up with the stages.
  jc_decode #(.STAGES(STAGES)) dec_i (
    .chain (chain_d),
    .hot   (hot_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      hot_q   <= HOT_ZERO;
    end else begin
      chain_q <= chain_d;
      hot_q   <= hot_d;
    end
  end

  assign stages    = chain_q;
  assign state_hot = hot_q;
endmodule

// File: rtl/jc_checker.sv
`timescale 1ns/1ps
module jc_checker #(
  parameter int                  STAGES = 4,
  parameter jc_pkg::jc_recover_e MODE   = jc_pkg::RECOVER_CLEAR
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clr,
  input logic                  en,
  input logic                  load_en,
  input logic [STAGES-1:0]     load_val,
  input logic [STAGES-1:0]     stages,
  input logic [2*STAGES-1:0]   state_hot
);
  localparam int NSTATE = 2 * STAGES;
  localparam int CW     = $clog2(STAGES) + 2;

  // Pattern of state k built from the sequence definition.
  function automatic logic [STAGES-1:0] pat_of(int k);
    logic [STAGES-1:0] r;
    r = '0;
    for (int i = 0; i < STAGES; i++) begin
      if (k <= STAGES) r[i] = (i < k);
      else             r[i] = (i >= k - STAGES);
    end
    return r;
  endfunction

  function automatic int index_of(logic [STAGES-1:0] v);
    int r;
    r = -1;
    for (int k = 0; k < NSTATE; k++) begin
      if (v == pat_of(k)) r = k;
    end
    return r;
  endfunction

  int                idx_c;
  logic              legal_c;
  logic [NSTATE-1:0] hot_exp;

  always_comb begin
    idx_c   = index_of(stages);
    legal_c = (idx_c >= 0);
    hot_exp = '0;
    for (int k = 0; k < NSTATE; k++) begin
      if (k == idx_c) hot_exp[k] = 1'b1;
    end
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (stages == '0) && (state_hot == NSTATE'(1)));

  // R2: decode advances one place (rotates) on a step
  a_r2_step_rotates: assert property (@(posedge clk) disable iff (rst)
    (legal_c && en && !clr && !load_en) |=>
      (state_hot == {$past(state_hot[NSTATE-2:0]), $past(state_hot[NSTATE-1])}));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (legal_c && !en && !clr && !load_en) |=> ($stable(stages) && $stable(state_hot)));

  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (stages == '0) && (state_hot == NSTATE'(1)));

  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    (load_en && !clr) |=> (stages == $past(load_val)));

  a_r6_onehot_decode: assert property (@(posedge clk) disable iff (rst)
    legal_c |-> ($onehot0(state_hot) && (state_hot == hot_exp)));

  generate
    if (MODE == jc_pkg::RECOVER_CLEAR) begin : g_chk_clear
      a_r7_recover_one_clock: assert property (@(posedge clk) disable iff (rst)
        (!legal_c && !clr && !load_en) |=> (stages == '0));
    end else begin : g_chk_drain
      logic [CW-1:0] bad_run;
      always_ff @(posedge clk) begin
        if (rst || legal_c || clr || load_en) bad_run <= '0;
        else if (bad_run != '1)               bad_run <= bad_run + 1'b1;
      end
      a_r7_recover_bounded: assert property (@(posedge clk) disable iff (rst)
        !legal_c |-> (bad_run < CW'(STAGES)));
    end
  endgenerate
endmodule

bind johnson_ring_decoder jc_checker #(.STAGES(STAGES), .MODE(MODE)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .en        (en),
  .load_en   (load_en),
  .load_val  (load_val),
  .stages    (stages),
  .state_hot (state_hot)
);

// File: tb/johnson_ring_decoder_tb.sv
`timescale 1ns/1ps
module johnson_ring_decoder_tb_top;
  localparam int N  = 4;
  localparam int NS = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          en = 1'b0;
  logic          load_en = 1'b0;
  logic [N-1:0]  load_val = '0;
  logic [N-1:0]  stages;
  logic [NS-1:0] state_hot;

  int checks = 0;
  int fails  = 0;
  int idx    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  johnson_ring_decoder #(.STAGES(N)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .en(en), .load_en(load_en),
    .load_val(load_val), .stages(stages), .state_hot(state_hot)
  );

  // Expected four-stage sequence, bit 0 = first stage.
  function automatic logic [N-1:0] seq(int k);
    case (k % NS)
      0: return 4'h0; 1: return 4'h1; 2: return 4'h3; 3: return 4'h7;
      4: return 4'hF; 5: return 4'hE; 6: return 4'hC; default: return 4'h8;
    endcase
  endfunction

  function automatic int find_idx(logic [N-1:0] v);
    int r = -1;
    for (int k = 0; k < NS; k++) if (seq(k) == v) r = k;
    return r;
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_state(string req, int k);
    logic [NS-1:0] eh;
    eh = NS'(1) << k;
    checks++;
    if (stages !== seq(k) || state_hot !== eh) begin
      fails++;
      $display("FAIL %s stages=%h exp=%h hot=%b exp=%b", req, stages, seq(k), state_hot, eh);
    end
  endtask

  task automatic expect_raw(string req, logic [N-1:0] ev);
    checks++;
    if (stages !== ev) begin
      fails++;
      $display("FAIL %s stages=%h exp=%h", req, stages, ev);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; load_en = 1'b1; load_val = 4'h5; clr = 1'b0;
    cyc(); cyc();
    expect_state("R1 reset dominates", 0);
    rst = 1'b0; en = 1'b0; load_en = 1'b0;
    cyc();
    expect_state("R1 after release", 0);
    idx = 0;
  endtask

  task automatic t_full_cycle();
    en = 1'b1;
    for (int i = 0; i < 2 * NS; i++) begin
      cyc();
      idx = (idx + 1) % NS;
      expect_state("R2/R6 step and decode", idx);
    end
    en = 1'b0;
  endtask

  task automatic t_hold();
    en = 1'b1; cyc(); cyc(); cyc(); idx = (idx + 3) % NS;
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cyc();
      expect_state("R3 hold", idx);
    end
  endtask

  task automatic t_enable_pattern();
    bit pat [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 6; i++) begin
      en = pat[i];
      cyc();
      if (pat[i]) idx = (idx + 1) % NS;
      expect_state("R2/R3 gated steps", idx);
    end
    en = 1'b0;
  endtask

  task automatic t_clear();
    clr = 1'b1; en = 1'b1; load_en = 1'b1; load_val = 4'h3;
    cyc();
    clr = 1'b0; load_en = 1'b0; en = 1'b0;
    idx = 0;
    expect_state("R4 clear over load and enable", 0);
  endtask

  task automatic t_load();
    load_en = 1'b1; load_val = 4'hC; en = 1'b1;
    cyc();
    load_en = 1'b0;
    idx = 6;
    expect_state("R5 load legal", idx);
    cyc(); idx = 7; expect_state("R2 after load", idx);
    cyc(); idx = 0; expect_state("R2 wrap to zero", idx);
    load_en = 1'b1; load_val = 4'h7; en = 1'b0;
    cyc();
    load_en = 1'b0; idx = 3;
    expect_state("R5 load with enable low", idx);
  endtask

  task automatic t_illegal();
    for (int v = 0; v < 16; v++) begin
      if (find_idx(4'(v)) < 0) begin
        load_en = 1'b1; load_val = 4'(v); en = 1'b0;
        cyc();
        load_en = 1'b0;
        expect_raw("R5 illegal load", 4'(v));
        cyc();
        expect_state("R7 recovery with enable low", 0);
      end
    end
    idx = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_cycle();
    t_hold();
    t_enable_pattern();
    t_clear();
    t_load();
    t_illegal();
    t_full_cycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule